// File: doc/BRIEF.md
# Loop-Detecting Branch Target Buffer

This block is a four-entry, fully associative target cache for direct branches in a short in-order fetch pipeline. Each cycle the fetch stage presents a program counter. If a stored branch matches, the block returns the remembered destination in the same cycle. It also flags whether that destination is a short backward hop of at most eight 16-bit instructions. When that flag is set, the fetch logic can replay the loop body from its instruction queue instead of refetching it.

Branch outcomes come back from the decode stage on a separate resolution port, one direct branch at a time, in the same cycle. The block compares the outcome with its own contents:
- When a branch was predicted taken but falls through, the block drops the entry and requests a queue flush.
- When a taken branch was missing or had the wrong destination, the block writes the correct destination and requests a flush.
- A new branch goes into a free slot if one exists. Otherwise it replaces the slot chosen by a three-bit pseudo-LRU tree.
- When the lookup and the resolution touch the same entry in one cycle, the lookup sees the contents the resolution is writing.

Top module: `loop_btb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses; with `lu_valid` low, `lu_hit` and `lu_loop` are 0.
- R2: An entry's tag is the branch PC without bit 0. A lookup whose PC matches a valid tag asserts `lu_hit` and drives the stored destination on `lu_target` in the same cycle.
- R3: `lu_loop` is 1 exactly when `lu_hit` is 1, `lu_target` <= `lu_pc`, and `lu_pc - lu_target` <= 2*LOOP_SPAN bytes. With the default this is 16 bytes, or 8 two-byte instructions.
- R4: A resolution of a not-taken branch that hits a valid entry asserts `rs_flush` in that cycle. The entry is invalidated, so a later lookup of that PC misses.
- R5: A taken resolution asserts `rs_flush` in that cycle when it misses, and the destination is allocated. It also asserts `rs_flush` when the stored destination differs from `rs_target`; that entry is then overwritten in place, and no other entry is disturbed.
- R6: A correct prediction leaves `rs_flush` at 0 and changes no stored branch. A correct prediction is either a hit that is taken to the stored destination, or a miss that is not taken.
- R7: Allocation picks the lowest-numbered invalid entry when one exists.
- R8: With all entries valid, allocation replaces the pseudo-LRU victim. The tree has three bits. Bit 0 = 1 selects the pair {2,3}, bit 0 = 0 selects {0,1}. Bit 1 picks entry 1 over 0, and bit 2 picks entry 3 over 2. The victim is entry 1 when bit 0 = 0 and bit 1 = 1, entry 0 when both are 0, entry 3 when bit 0 = 1 and bit 2 = 1, and entry 2 when bit 0 = 1 and bit 2 = 0. Every lookup hit and every write turns the bits away from the touched entry; when both occur in one cycle, the write is applied last.
- R9: When a resolution writes or invalidates the entry a same-cycle lookup hits, or writes the PC being looked up, the lookup result reflects the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_valid | input | 1 | Fetch lookup request |
| lu_pc | input | PC_W | Fetch PC to look up |
| lu_hit | output | 1 | Lookup matched a branch |
| lu_target | output | PC_W | Predicted destination |
| lu_loop | output | 1 | Short backward loop detected |
| rs_valid | input | 1 | Decode resolves a direct branch |
| rs_pc | input | PC_W | PC of the resolved branch |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | PC_W | Actual destination |
| rs_flush | output | 1 | Misprediction, flush the queue |

## Verification
A wrong valid bit or tag shows at once on the next lookup of that PC as a false hit or a false miss. It also shows on the next resolution of that PC as a flush that should not happen, or a missing flush. A wrong pseudo-LRU state stays hidden until the buffer is full and a fifth branch is allocated. At that point the wrong older branch disappears, which the next lookups reveal. The bench therefore sweeps a small pool of branch PCs with a reference model through many full-buffer evictions, and checks each lookup and flush in the cycle it is produced.

// File: rtl/loop_btb.sv
module loop_btb #(
  parameter int PC_W      = 32,
  parameter int LOOP_SPAN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lu_valid,
  input  logic [PC_W-1:0] lu_pc,
  output logic            lu_hit,
  output logic [PC_W-1:0] lu_target,
  output logic            lu_loop,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  output logic            rs_flush
);
  localparam int N = 4;
  localparam int TAG_W = PC_W - 1;
  localparam logic [PC_W-1:0] SPAN_B = PC_W'(2 * LOOP_SPAN);

  logic [N-1:0]     vld;
  logic [TAG_W-1:0] tag_q [N];
  logic [PC_W-1:0]  tgt_q [N];
  logic [2:0]       plru, plru_nx;
  logic [N-1:0]     lu_m, rs_m;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign lu_m[i] = vld[i] && tag_q[i] == lu_pc[PC_W-1:1];
    assign rs_m[i] = vld[i] && tag_q[i] == rs_pc[PC_W-1:1];
  end

  function automatic logic [1:0] enc(input logic [N-1:0] m);
    enc = '0;
    for (int i = 0; i < N; i++) if (m[i]) enc = 2'(i);
  endfunction

  function automatic logic [2:0] touch(input logic [2:0] p, input logic [1:0] e);
    touch = p;
    touch[0] = ~e[1];
    if (e[1]) touch[2] = ~e[0];
    else      touch[1] = ~e[0];
  endfunction

  logic       rs_hit, mispred, wr_en, inv_en, lu_raw, clobber, fwd;
  logic [1:0] rs_idx, lu_idx, victim, wr_idx, hit_idx;

  assign rs_hit  = |rs_m;
  assign rs_idx  = enc(rs_m);
  assign mispred = rs_valid && (rs_hit ? (!rs_taken || tgt_q[rs_idx] != rs_target) : rs_taken);
  assign wr_en   = mispred && rs_taken;
  assign inv_en  = mispred && !rs_taken;
  assign rs_flush = mispred;

  always_comb begin
    if      (!vld[0]) victim = 2'd0;
    else if (!vld[1]) victim = 2'd1;
    else if (!vld[2]) victim = 2'd2;
    else if (!vld[3]) victim = 2'd3;
    else victim = plru[0] ? (plru[2] ? 2'd3 : 2'd2) : (plru[1] ? 2'd1 : 2'd0);
  end
  assign wr_idx = rs_hit ? rs_idx : victim;

  assign lu_raw  = lu_valid && |lu_m;
  assign lu_idx  = enc(lu_m);
  assign clobber = (wr_en || inv_en) && lu_idx == wr_idx;
  assign fwd     = lu_valid && wr_en && lu_pc[PC_W-1:1] == rs_pc[PC_W-1:1];

  assign lu_hit    = fwd || (lu_raw && !clobber);
  assign lu_target = fwd ? rs_target : tgt_q[lu_idx];
  assign hit_idx   = fwd ? wr_idx : lu_idx;
  assign lu_loop   = lu_hit && lu_target <= lu_pc && (lu_pc - lu_target) <= SPAN_B;

  always_comb begin
    plru_nx = plru;
    if (lu_hit) plru_nx = touch(plru_nx, hit_idx);
    if (wr_en)  plru_nx = touch(plru_nx, wr_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      plru <= '0;
    end else begin
      plru <= plru_nx;
      if (wr_en)  vld[wr_idx] <= 1'b1;
      if (inv_en) vld[rs_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= rs_pc[PC_W-1:1];
      tgt_q[wr_idx] <= rs_target;
    end
  end

  assert_idle_lookup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_valid |-> !lu_hit && !lu_loop);

  assert_unique_tags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lu_m));

  assert_not_taken_gone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_taken ##1 rs_valid && !rs_taken && rs_pc == $past(rs_pc) |-> !rs_flush);

  assert_single_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) + 1 >= $past($countones(vld)));

  assert_retry_no_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_taken ##1 rs_valid && rs_taken && rs_pc == $past(rs_pc)
      && rs_target == $past(rs_target) |-> !rs_flush);

  assert_plru_away_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lu_hit && !rs_valid && (&vld) |=> victim != $past(hit_idx));
endmodule

// File: tb/sim_loop_btb.sv
`timescale 1ns/1ps
module sim_loop_btb;
  logic clk = 0, rst_n = 0;
  logic lu_valid = 0, rs_valid = 0, rs_taken = 0;
  logic [31:0] lu_pc = 0, rs_pc = 0, rs_target = 0;
  logic lu_hit, lu_loop, rs_flush;
  logic [31:0] lu_target;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  loop_btb #(.PC_W(32), .LOOP_SPAN(8)) u0 (
    .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_pc(lu_pc),
    .lu_hit(lu_hit), .lu_target(lu_target), .lu_loop(lu_loop),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_flush(rs_flush));

  logic        mv [4];
  logic [30:0] mt [4];
  logic [31:0] mg [4];
  logic [2:0]  mp;

  function automatic logic [2:0] mtouch(input logic [2:0] p, input int e);
    logic [2:0] q = p;
    case (e)
      0: begin q[0] = 1; q[1] = 1; end
      1: begin q[0] = 1; q[1] = 0; end
      2: begin q[0] = 0; q[2] = 1; end
      default: begin q[0] = 0; q[2] = 0; end
    endcase
    return q;
  endfunction

  function automatic int mvictim();
    for (int k = 0; k < 4; k++) if (!mv[k]) return k;
    if (!mp[0]) return mp[1] ? 1 : 0;
    return mp[2] ? 3 : 2;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [31:0] lpc, input logic rv,
                      input logic [31:0] rpc, input logic rt, input logic [31:0] rtg,
                      input string rq);
    int li, ri, wi, hi;
    logic mis, wr, inv, eh, el;
    logic [31:0] et;
    @(negedge clk);
    lu_valid = lv; lu_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_target = rtg;
    #1;
    li = -1; ri = -1;
    for (int k = 0; k < 4; k++) begin
      if (mv[k] && mt[k] == lpc[31:1]) li = k;
      if (mv[k] && mt[k] == rpc[31:1]) ri = k;
    end
    mis = rv && ((ri >= 0) ? (!rt || mg[ri] != rtg) : rt);
    wr = mis && rt;
    inv = mis && !rt;
    wi = (ri >= 0) ? ri : mvictim();
    eh = 0; et = 0; hi = 0;
    if (lv && wr && lpc[31:1] == rpc[31:1]) begin eh = 1; et = rtg; hi = wi; end
    else if (lv && li >= 0 && !((wr || inv) && li == wi)) begin eh = 1; et = mg[li]; hi = li; end
    el = eh && et <= lpc && (lpc - et) <= 32'd16;
    chk(rq, "lu_hit", {31'd0, lu_hit}, {31'd0, eh});
    if (eh) chk(rq, "lu_target", lu_target, et);
    chk(rq, "lu_loop", {31'd0, lu_loop}, {31'd0, el});
    chk(rq, "rs_flush", {31'd0, rs_flush}, {31'd0, mis});
    if (eh) mp = mtouch(mp, hi);
    if (wr) begin mv[wi] = 1; mt[wi] = rpc[31:1]; mg[wi] = rtg; mp = mtouch(mp, wi); end
    if (inv) mv[ri] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc, t;
    int r;
    for (int k = 0; k < 4; k++) begin mv[k] = 0; mt[k] = 0; mg[k] = 0; end
    mp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: empty after reset, idle lookup
    step(1, 32'h100, 0, 0, 0, 0, "R1");
    step(0, 32'h100, 0, 0, 0, 0, "R1");
    // R6: miss not taken does nothing
    step(0, 0, 1, 32'h200, 0, 32'h180, "R6");
    step(1, 32'h200, 0, 0, 0, 0, "R6");
    // R5, R2, R7: allocate four branches into free slots
    for (int k = 0; k < 4; k++) step(0, 0, 1, 32'h400 + 32'(k*2), 1, 32'h3F0 + 32'(k*4), "R5");
    for (int k = 0; k < 4; k++) step(1, 32'h400 + 32'(k*2), 0, 0, 0, 0, "R2");
    // R6: correct taken prediction
    step(1, 32'h402, 1, 32'h400, 1, 32'h3F0, "R6");
    // R5: wrong target rewritten in place
    step(0, 0, 1, 32'h404, 1, 32'h500, "R5");
    for (int k = 0; k < 4; k++) step(1, 32'h400 + 32'(k*2), 0, 0, 0, 0, "R5");
    // R4 then R7: invalidate, then refill the hole
    step(0, 0, 1, 32'h402, 0, 0, "R4");
    step(1, 32'h402, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 32'h600, 1, 32'h5F8, "R7");
    for (int k = 0; k < 4; k++) step(1, 32'h400 + 32'(k*2), 0, 0, 0, 0, "R7");
    step(1, 32'h600, 0, 0, 0, 0, "R7");
    // R8: full buffer, touch then evict
    step(1, 32'h400, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 32'h700, 1, 32'h6F0, "R8");
    step(1, 32'h406, 0, 0, 0, 0, "R8");
    step(1, 32'h600, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 32'h702, 1, 32'h6F0, "R8");
    step(1, 32'h404, 0, 0, 0, 0, "R8");
    step(1, 32'h400, 0, 0, 0, 0, "R8");
    // R9: same-cycle precedence
    step(1, 32'h700, 1, 32'h700, 0, 0, "R9");
    step(1, 32'h702, 1, 32'h702, 1, 32'h6E0, "R9");
    step(1, 32'h800, 1, 32'h800, 1, 32'h7FC, "R9");
    step(1, 32'h400, 1, 32'h804, 1, 32'h7F0, "R9");
    // R3: loop distance sweep, backward and forward
    for (int d = -4; d <= 12; d++) begin
      pc = 32'h2000 + 32'((d + 8) * 64);
      t = pc - 32'(2 * d);
      step(0, 0, 1, pc, 1, t, "R3");
      step(1, pc, 0, 0, 0, 0, "R3");
    end
    // sweep over a small PC pool with frequent eviction
    for (int n = 0; n < 2500; n++) begin
      r = $urandom;
      pc = 32'h3000 + 32'(2 * ((r >> 2) % 6));
      t = pc - 32'(2 * ((r >> 6) % 12)) + 32'd4;
      step(r[0], 32'h3000 + 32'(2 * ((r >> 10) % 6)), r[1], pc, r[12], t,
           r[0] ? "R2" : "R1");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule